// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside an 8-bit microcontroller core and decides which of eight interrupt requests the core should service next. The sources are four active-low external pins, two timer overflow events, a serial port request and a combined request from a second timer. Each source has its own enable bit, and a single global enable gates all of them. Two priority bits per source place it on one of four levels. Inside a level, a fixed polling order breaks ties.

The controller presents the winning request to the core as a request line, a source index, a level and a vector address. When the core starts a service routine it pulses `vec_take`. The controller then marks that level as in service and clears the request flag where the source class calls for it. When the routine ends, the core pulses `reti` and the highest in-service level is released. A request is offered only when its level is strictly above every level still in service, so nesting works one level at a time.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, `irq_req` is 0, every bit of `pend_flags` is 0 while the external pins are high and the timer pulses are low, and no level is in service.
- R2: While `glb_en` is 0, `irq_req` stays 0 whatever the other inputs are.
- R3: A source whose `src_en` bit is 0 is never the one reported, even when it is pending.
- R4: Among enabled pending sources, the source with the highest level `{pri_hi[i], pri_lo[i]}` is reported, and `irq_lvl` equals that level (3 highest, 0 lowest).
- R5: Among enabled pending sources on the same level, the lowest source index wins. Indices 0 to 7 are ext0, timer0, ext1, timer1, serial, timer2, ext2 and ext3, and `irq_vec` = 8'h03 + 8 × index.
- R6: While some level is in service, a request is reported only if its level is strictly greater than the highest in-service level. With nothing in service, a level-0 request is reported.
- R7: A `reti` pulse releases only the highest in-service level. A `reti` with nothing in service has no effect.
- R8: An external source whose `ext_mode` bit is 1 (edge mode) latches a request on a falling edge of its pin, keeps it after the pin returns high, and drops it when its vector is taken. With `ext_mode` bit 0 (level mode), the request follows the pin and is not cleared by a vector take.
- R9: A one-cycle `tmr0_ovf` or `tmr1_ovf` pulse sets that timer's pending flag (`pend_flags` bit 1 or 3) on the next clock. The flag is cleared when that source's vector is taken.
- R10: `pend_flags[4]` is the OR of `ser_rx` and `ser_tx`, and `pend_flags[5]` is the OR of `t2_ovf` and `t2_ext`. A vector take does not clear either of them.
- R11: External pins pass through two flip-flops. A level-mode request appears in `pend_flags` after two rising clock edges. An edge-mode request appears after three edges and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| glb_en | input | 1 | Global interrupt enable |
| src_en | input | 8 | Per-source enable, indexed in polling order |
| pri_hi | input | 8 | High priority bit per source |
| pri_lo | input | 8 | Low priority bit per source |
| ext_mode | input | 4 | Per external pin: 1 = falling-edge, 0 = level |
| ext_n | input | 4 | Active-low external request pins ext0..ext3 |
| tmr0_ovf | input | 1 | Timer0 overflow pulse |
| tmr1_ovf | input | 1 | Timer1 overflow pulse |
| ser_rx | input | 1 | Serial receive flag |
| ser_tx | input | 1 | Serial transmit flag |
| t2_ovf | input | 1 | Timer2 overflow flag |
| t2_ext | input | 1 | Timer2 external event flag |
| vec_take | input | 1 | Core strobe: vector for the reported request taken |
| reti | input | 1 | Core strobe: return from interrupt |
| irq_req | output | 1 | A request is offered to the core |
| irq_src | output | 3 | Index of the offered source |
| irq_lvl | output | 2 | Level of the offered source |
| irq_vec | output | 8 | Vector address of the offered source |
| pend_flags | output | 8 | Raw pending request per source, before enables |

## Verification
Arbitration is swept over all 256 enable masks with every source pending, under four priority maps. With a flat map, only the polling order picks the winner. With the mixed maps, level ordering and the enable masking are tested separately. A nested sequence of three takes and four returns shows whether the in-service levels block a request at the same or a lower level and whether each return releases only the top level. Directed pin waveforms in edge and level mode, timer pulses and the flag pairs of the serial and timer2 sources show which flags are latched, which are followed, which are cleared, and after how many clock edges each one appears.

// File: rtl/irq_pkg.sv
// Shared constants and types for the interrupt controller.
// Assumes eight sources in fixed polling order and four priority levels.
package irq_pkg;
    localparam int NSRC = 8;
    localparam int NEXT = 4;
    localparam int NTMR = 2;
    localparam int NLVL = 4;
    localparam int LVLW = $clog2(NLVL);
    localparam int IDXW = $clog2(NSRC);
    localparam int VECW = 8;
    localparam int VEC_SHIFT = 3;
    localparam logic [VECW-1:0] VEC_BASE = 8'h03;

    typedef logic [LVLW-1:0] lvl_t;
    typedef logic [IDXW-1:0] idx_t;

    // Source slots in polling order, highest first
    typedef enum logic [IDXW-1:0] {
        SRC_EXT0, SRC_TMR0, SRC_EXT1, SRC_TMR1,
        SRC_SER,  SRC_TMR2, SRC_EXT2, SRC_EXT3
    } src_e;

    // Vector address for a given polling slot
    function automatic logic [VECW-1:0] vec_of(idx_t idx);
        return VEC_BASE + (VECW'(idx) << VEC_SHIFT);
    endfunction
endpackage

// File: rtl/irq_ext_sync.sv
// One external request channel: synchronizer, falling-edge detector and
// request flag. Assumes an active-low asynchronous pin. In edge mode the
// flag is latched on a 1-to-0 step of the synchronized value and dropped on
// clr; in level mode the request follows the pin and the flag is held at 0.
module irq_ext_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic clr,
    output logic req
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   sampled;
    logic                   prev_q;
    logic                   fall;
    logic                   flag_q;

    assign sampled = sync_q[SYNC_STAGES-1];
    assign fall    = prev_q & ~sampled;

    // Shift the pin through the synchronizer; idle value is high
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
    end

    // Remember the previous synchronized sample for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= sampled;
    end

    // Edge flag: a new edge beats a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)          flag_q <= 1'b0;
        else if (!edge_mode) flag_q <= 1'b0;
        else if (fall)       flag_q <= 1'b1;
        else if (clr)        flag_q <= 1'b0;
    end

    // Select the request source by mode
    always_comb begin
        req = edge_mode ? flag_q : ~sampled;
    end
endmodule

// File: rtl/irq_arbiter.sv
// Combinational winner selection. Assumes masked requests at the input.
// The highest level wins; on a tie the lowest slot index wins.
module irq_arbiter
    import irq_pkg::*;
(
    input  logic [NSRC-1:0] req,
    input  logic [NSRC-1:0] pri_hi,
    input  logic [NSRC-1:0] pri_lo,
    output logic            found,
    output idx_t            win_idx,
    output lvl_t            win_lvl,
    output logic [NSRC-1:0] grant
);
    lvl_t src_lvl [NSRC];

    // Form each source's level from its two priority bits
    always_comb begin
        for (int i = 0; i < NSRC; i++) begin
            src_lvl[i] = {pri_hi[i], pri_lo[i]};
        end
    end

    // Scan low to high level, high to low slot: the last hit is the winner
    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        win_lvl = '0;
        for (int l = 0; l < NLVL; l++) begin
            for (int i = NSRC - 1; i >= 0; i--) begin
                if (req[i] && src_lvl[i] == lvl_t'(l)) begin
                    found   = 1'b1;
                    win_idx = idx_t'(i);
                    win_lvl = lvl_t'(l);
                end
            end
        end
    end

    // One-hot grant of the winning slot
    always_comb begin
        grant = '0;
        if (found) grant[win_idx] = 1'b1;
    end
endmodule

// File: rtl/irq_level_stack.sv
// In-service level tracker: one bit per priority level. A push marks a
// level; a pop releases the highest marked level. Assumes the caller pushes
// only a level above the current top.
module irq_level_stack
    import irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  lvl_t            push_lvl,
    input  logic            pop,
    output logic [NLVL-1:0] active,
    output logic            any,
    output lvl_t            top_lvl
);
    logic [NLVL-1:0] pop_mask;
    logic [NLVL-1:0] push_mask;

    // Find the highest level in service
    always_comb begin
        any     = |active;
        top_lvl = '0;
        for (int l = 0; l < NLVL; l++) begin
            if (active[l]) top_lvl = lvl_t'(l);
        end
    end

    // Build the release and mark masks for this cycle
    always_comb begin
        pop_mask  = '0;
        push_mask = '0;
        if (pop && any) pop_mask[top_lvl] = 1'b1;
        if (push)       push_mask[push_lvl] = 1'b1;
    end

    // Update the in-service bits: release first, then mark
    always_ff @(posedge clk) begin
        if (!rst_n) active <= '0;
        else        active <= (active & ~pop_mask) | push_mask;
    end
endmodule

// File: rtl/irq_vec_ctrl.sv
// Top of the prioritized vectored interrupt controller. Collects the eight
// source requests, applies enables, arbitrates, gates the winner against
// the in-service levels and clears flags on a vector take. Assumes the core
// asserts vec_take only while irq_req is high and that all strobes are one
// cycle wide.
module irq_vec_ctrl
    import irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            glb_en,
    input  logic [NSRC-1:0] src_en,
    input  logic [NSRC-1:0] pri_hi,
    input  logic [NSRC-1:0] pri_lo,
    input  logic [NEXT-1:0] ext_mode,
    input  logic [NEXT-1:0] ext_n,
    input  logic            tmr0_ovf,
    input  logic            tmr1_ovf,
    input  logic            ser_rx,
    input  logic            ser_tx,
    input  logic            t2_ovf,
    input  logic            t2_ext,
    input  logic            vec_take,
    input  logic            reti,
    output logic            irq_req,
    output logic [IDXW-1:0] irq_src,
    output logic [LVLW-1:0] irq_lvl,
    output logic [VECW-1:0] irq_vec,
    output logic [NSRC-1:0] pend_flags
);
    localparam int EXT_SLOT [NEXT] = '{int'(SRC_EXT0), int'(SRC_EXT1), int'(SRC_EXT2), int'(SRC_EXT3)};
    localparam int TMR_SLOT [NTMR] = '{int'(SRC_TMR0), int'(SRC_TMR1)};

    logic [NEXT-1:0] ext_req;
    logic [NTMR-1:0] tmr_set;
    logic [NTMR-1:0] tmr_flag;
    logic [NSRC-1:0] masked;
    logic [NSRC-1:0] grant;
    logic [NSRC-1:0] clr_src;
    logic            found;
    idx_t            win_idx;
    lvl_t            win_lvl;
    logic [NLVL-1:0] isr_act;
    logic            isr_any;
    lvl_t            isr_top;
    logic            accept;
    logic            take;

    assign tmr_set = {tmr1_ovf, tmr0_ovf};

    // External channels, one per pin
    for (genvar g = 0; g < NEXT; g++) begin : g_ext
        irq_ext_sync #(.SYNC_STAGES(SYNC_STAGES)) u_ext (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_n     (ext_n[g]),
            .edge_mode (ext_mode[g]),
            .clr       (clr_src[EXT_SLOT[g]]),
            .req       (ext_req[g])
        );
    end

    // Timer overflow flags, set by pulse and cleared on vector take
    for (genvar t = 0; t < NTMR; t++) begin : g_tmr
        // Hold the overflow until vectored; a new pulse beats a clear
        always_ff @(posedge clk) begin
            if (!rst_n)                    tmr_flag[t] <= 1'b0;
            else if (tmr_set[t])           tmr_flag[t] <= 1'b1;
            else if (clr_src[TMR_SLOT[t]]) tmr_flag[t] <= 1'b0;
        end
    end

    // Gather the raw requests into polling-order slots
    always_comb begin
        pend_flags = '0;
        for (int g = 0; g < NEXT; g++) pend_flags[EXT_SLOT[g]] = ext_req[g];
        for (int t = 0; t < NTMR; t++) pend_flags[TMR_SLOT[t]] = tmr_flag[t];
        pend_flags[SRC_SER]  = ser_rx | ser_tx;
        pend_flags[SRC_TMR2] = t2_ovf | t2_ext;
    end

    // Apply global and per-source enables
    always_comb begin
        masked = glb_en ? (pend_flags & src_en) : '0;
    end

    irq_arbiter u_arb (
        .req     (masked),
        .pri_hi  (pri_hi),
        .pri_lo  (pri_lo),
        .found   (found),
        .win_idx (win_idx),
        .win_lvl (win_lvl),
        .grant   (grant)
    );

    // Offer the winner only if it outranks every level in service
    always_comb begin
        accept = found && (!isr_any || (win_lvl > isr_top));
        take   = vec_take && accept;
    end

    // Hardware clears apply to timers and to edge-mode external slots
    always_comb begin
        clr_src = '0;
        if (take) begin
            for (int t = 0; t < NTMR; t++) clr_src[TMR_SLOT[t]] = grant[TMR_SLOT[t]];
            for (int g = 0; g < NEXT; g++) clr_src[EXT_SLOT[g]] = grant[EXT_SLOT[g]] & ext_mode[g];
        end
    end

    irq_level_stack u_isr (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (take),
        .push_lvl (win_lvl),
        .pop      (reti),
        .active   (isr_act),
        .any      (isr_any),
        .top_lvl  (isr_top)
    );

    // Drive the core-facing request outputs
    always_comb begin
        irq_req = accept;
        irq_src = accept ? win_idx : '0;
        irq_lvl = accept ? win_lvl : '0;
        irq_vec = accept ? vec_of(win_idx) : '0;
    end
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
// Property checker for irq_vec_ctrl, attached through bind. Observes ports
// and the in-service bits; drives nothing.
module irq_vec_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       glb_en,
    input logic [7:0] src_en,
    input logic       vec_take,
    input logic       reti,
    input logic       tmr0_ovf,
    input logic       irq_req,
    input logic [2:0] irq_src,
    input logic [1:0] irq_lvl,
    input logic [7:0] irq_vec,
    input logic [7:0] pend_flags,
    input logic [3:0] isr_act,
    input logic       isr_any,
    input logic [1:0] isr_top,
    input logic [7:0] grant
);
    // R2
    glb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> glb_en);

    // R3
    src_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> src_en[irq_src]);

    // R5
    vec_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vec[2:0] == 3'b011));

    // R5
    grant_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R6
    no_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && isr_any) |-> (irq_lvl > isr_top));

    // R7
    reti_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && isr_any && !(vec_take && irq_req)) |=>
            ($countones(isr_act) == $countones($past(isr_act)) - 1));

    // R9
    tmr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_take && irq_req && irq_src == 3'd1 && !tmr0_ovf) |=> !pend_flags[1]);
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .glb_en     (glb_en),
    .src_en     (src_en),
    .vec_take   (vec_take),
    .reti       (reti),
    .tmr0_ovf   (tmr0_ovf),
    .irq_req    (irq_req),
    .irq_src    (irq_src),
    .irq_lvl    (irq_lvl),
    .irq_vec    (irq_vec),
    .pend_flags (pend_flags),
    .isr_act    (isr_act),
    .isr_any    (isr_any),
    .isr_top    (isr_top),
    .grant      (grant)
);

// File: tb/irq_vec_ctrl_bench.sv
module irq_vec_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] CFG_HI [4] = '{8'h00, 8'hA5, 8'h0F, 8'hF0};
    localparam logic [7:0] CFG_LO [4] = '{8'h00, 8'h3C, 8'h55, 8'hCC};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       glb_en = 1'b0;
    logic [7:0] src_en = '0;
    logic [7:0] pri_hi = '0;
    logic [7:0] pri_lo = '0;
    logic [3:0] ext_mode = '0;
    logic [3:0] ext_n = 4'hF;
    logic       tmr0_ovf = 1'b0;
    logic       tmr1_ovf = 1'b0;
    logic       ser_rx = 1'b0;
    logic       ser_tx = 1'b0;
    logic       t2_ovf = 1'b0;
    logic       t2_ext = 1'b0;
    logic       vec_take = 1'b0;
    logic       reti = 1'b0;
    logic       irq_req;
    logic [2:0] irq_src;
    logic [1:0] irq_lvl;
    logic [7:0] irq_vec;
    logic [7:0] pend_flags;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    irq_vec_ctrl u_irq_vec_ctrl (
        .clk (clk), .rst_n (rst_n), .glb_en (glb_en), .src_en (src_en),
        .pri_hi (pri_hi), .pri_lo (pri_lo), .ext_mode (ext_mode), .ext_n (ext_n),
        .tmr0_ovf (tmr0_ovf), .tmr1_ovf (tmr1_ovf), .ser_rx (ser_rx), .ser_tx (ser_tx),
        .t2_ovf (t2_ovf), .t2_ext (t2_ext), .vec_take (vec_take), .reti (reti),
        .irq_req (irq_req), .irq_src (irq_src), .irq_lvl (irq_lvl), .irq_vec (irq_vec),
        .pend_flags (pend_flags)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Expected {req, vec, lvl} from the requirements; top = -1 when idle
    function automatic logic [10:0] model(logic [7:0] pend, logic [7:0] en, logic glb,
                                          logic [7:0] hi, logic [7:0] lo, int top);
        for (int l = 3; l >= 0; l--) begin
            for (int i = 0; i < 8; i++) begin
                if (glb && pend[i] && en[i] && int'({hi[i], lo[i]}) == l) begin
                    if (l > top) return {1'b1, 8'(8'h03 + 8 * i), 2'(l)};
                    return 11'd0;
                end
            end
        end
        return 11'd0;
    endfunction

    function automatic logic [10:0] observed();
        return irq_req ? {1'b1, irq_vec, irq_lvl} : 11'd0;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic pulse_take();
        vec_take = 1'b1;
        @(negedge clk);
        vec_take = 1'b0;
        #1;
    endtask

    task automatic pulse_reti();
        reti = 1'b1;
        @(negedge clk);
        reti = 1'b0;
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check
    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        #1;
        // R1: quiet after reset
        chk("R1 req", {31'd0, irq_req}, 32'd0);
        chk("R1 pend", {24'd0, pend_flags}, 32'd0);
        chk("R1 idle", {21'd0, observed()}, 32'd0);

        // Make all eight sources pending: level pins low, timers pulsed, flag pairs
        step(1);
        ext_n = 4'h0;
        tmr0_ovf = 1'b1;
        tmr1_ovf = 1'b1;
        ser_rx = 1'b1;
        t2_ovf = 1'b1;
        step(1);
        tmr0_ovf = 1'b0;
        tmr1_ovf = 1'b0;
        step(3);
        #1;
        chk("R9 R10 all pending", {24'd0, pend_flags}, 32'hFF);

        // R3 R4 R5: every enable mask under four priority maps
        glb_en = 1'b1;
        for (int c = 0; c < 4; c++) begin
            for (int m = 0; m < 256; m++) begin
                src_en = 8'(m);
                pri_hi = CFG_HI[c];
                pri_lo = CFG_LO[c];
                #1;
                chk(c == 0 ? "R3 R5 sweep" : "R3 R4 sweep", {21'd0, observed()},
                    {21'd0, model(8'hFF, src_en, 1'b1, pri_hi, pri_lo, -1)});
            end
        end

        // R2: global enable off masks all maps
        glb_en = 1'b0;
        src_en = 8'hFF;
        for (int c = 0; c < 4; c++) begin
            pri_hi = CFG_HI[c];
            pri_lo = CFG_LO[c];
            #1;
            chk("R2 global off", {31'd0, irq_req}, 32'd0);
        end
        glb_en = 1'b1;
        step(1);

        // R6 R7 R9: nesting; timer0 at level 3, serial at 1, timer2 at 2
        pri_hi = 8'b0010_0010;
        pri_lo = 8'b0001_0010;
        src_en = 8'b0001_0000;
        #1;
        chk("R6 idle serial", {21'd0, observed()}, {21'd0, 1'b1, 8'h23, 2'd1});
        pulse_take();
        chk("R6 serial blocks itself", {31'd0, irq_req}, 32'd0);
        src_en = 8'b0011_0000;
        #1;
        chk("R6 timer2 above serial", {21'd0, observed()}, {21'd0, 1'b1, 8'h2B, 2'd2});
        pulse_take();
        src_en = 8'b0011_0011;
        #1;
        chk("R6 timer0 above all", {21'd0, observed()}, {21'd0, 1'b1, 8'h0B, 2'd3});
        pulse_take();
        chk("R9 timer0 cleared", {31'd0, pend_flags[1]}, 32'd0);
        chk("R9 timer1 kept", {31'd0, pend_flags[3]}, 32'd1);
        chk("R10 flags kept", {30'd0, pend_flags[5:4]}, 32'd3);
        chk("R6 nothing above 3", {31'd0, irq_req}, 32'd0);
        pulse_reti();
        chk("R7 top 2 blocks", {31'd0, irq_req}, 32'd0);
        pulse_reti();
        chk("R7 top 1 admits 2", {21'd0, observed()}, {21'd0, 1'b1, 8'h2B, 2'd2});
        pulse_reti();
        chk("R7 empty", {21'd0, observed()}, {21'd0, 1'b1, 8'h2B, 2'd2});
        pulse_reti();
        chk("R7 extra return", {21'd0, observed()}, {21'd0, 1'b1, 8'h2B, 2'd2});

        // R9: timer pulse sets its flag on the next edge
        tmr0_ovf = 1'b1;
        step(1);
        tmr0_ovf = 1'b0;
        #1;
        chk("R9 timer0 set", {31'd0, pend_flags[1]}, 32'd1);

        // R10: every pair combination
        for (int v = 0; v < 4; v++) begin
            ser_rx = v[0];
            ser_tx = v[1];
            t2_ovf = v[1];
            t2_ext = v[0];
            #1;
            chk("R10 or pair", {30'd0, pend_flags[5:4]},
                {30'd0, (v != 0) ? 2'b11 : 2'b00});
        end

        // R8 R11: ext0 in edge mode
        src_en = 8'h00;
        pri_hi = 8'h00;
        pri_lo = 8'h00;
        ext_n = 4'hF;
        ext_mode = 4'b0001;
        step(4);
        #1;
        chk("R8 idle edge", {31'd0, pend_flags[0]}, 32'd0);
        step(1);
        ext_n[0] = 1'b0;
        step(2);
        #1;
        chk("R11 edge not yet", {31'd0, pend_flags[0]}, 32'd0);
        step(1);
        #1;
        chk("R11 edge after 3", {31'd0, pend_flags[0]}, 32'd1);
        ext_n[0] = 1'b1;
        step(4);
        #1;
        chk("R8 edge latched", {31'd0, pend_flags[0]}, 32'd1);
        src_en = 8'h01;
        #1;
        chk("R5 ext0 vector", {21'd0, observed()}, {21'd0, 1'b1, 8'h03, 2'd0});
        pulse_take();
        chk("R8 edge cleared", {31'd0, pend_flags[0]}, 32'd0);
        pulse_reti();

        // R8 R11: ext1 in level mode
        ext_n[1] = 1'b0;
        step(1);
        #1;
        chk("R11 level not yet", {31'd0, pend_flags[2]}, 32'd0);
        step(1);
        #1;
        chk("R11 level after 2", {31'd0, pend_flags[2]}, 32'd1);
        src_en = 8'h04;
        #1;
        chk("R5 ext1 vector", {21'd0, observed()}, {21'd0, 1'b1, 8'h13, 2'd0});
        pulse_take();
        chk("R8 level kept", {31'd0, pend_flags[2]}, 32'd1);
        pulse_reti();
        ext_n[1] = 1'b1;
        step(2);
        #1;
        chk("R8 level follows pin", {31'd0, pend_flags[2]}, 32'd0);

        finish_run();
    end
endmodule